// File: doc/BRIEF.md
# SDRAM Bank Command Legality Tracker

This block watches the command pins of an SDRAM interface: chip select, row strobe, column strobe and write enable. It samples them on every rising clock edge and turns each sample into a named command. It keeps a small state machine for every bank: idle, row open, read burst or write burst. It checks each command against the state of the bank it addresses, and against the state of all banks where the command concerns the whole device. A command that the state does not allow raises a one-cycle illegal strobe. That command then has no effect on the bank state.

Burst bookkeeping is part of the model. A read or write loads a per-bank beat counter from the burst-length code, and the bank returns to the row-open state once the burst has run its full length. A new read or write during a burst restarts the burst. A precharge during a burst cuts it short and closes the row. A burst-terminate command ends the burst and leaves the row open. The block sits beside a memory controller or a memory model as a protocol monitor, so it drives nothing back onto the bus.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high the command is INHIBIT (code 0) whatever the other pins are. It is always legal and changes no bank's state, although running bursts keep counting.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as follows: 111 NOP (1), 011 ACTIVE (2), 010 PRECHARGE (3), 001 AUTO REFRESH (4), 000 LOAD MODE (5), 101 READ (6), 100 WRITE (7), 110 BURST STOP (8). The code appears on `cmd_out`.
- R3: `cmd_out`, `illegal` and `bank_state` are registered. Each one reflects the command sampled at the same rising edge. Synchronous reset gives `cmd_out`=0, `illegal`=0 and every bank idle. Bank b occupies `bank_state[2b+1:2b]`, with idle=0, open=1, reading=2, writing=3.
- R4: For an idle bank, ACTIVE is legal and opens the row (state 1), and PRECHARGE is legal and leaves it idle. READ, WRITE and BURST STOP are illegal.
- R5: For a bank with an open row, READ moves it to reading and WRITE moves it to writing. ACTIVE and BURST STOP are illegal.
- R6: In a burst, a READ or WRITE to that bank is legal. It switches the state to match the new command and restarts the burst at the current burst length.
- R7: PRECHARGE is legal in every state and makes the bank idle, which also truncates a burst. BURST STOP during a burst returns the bank to the open state.
- R8: `burst_code` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. If a burst of L beats starts at edge n and nothing interrupts it, the bank reads as bursting after edges n to n+L-1 and as open after edge n+L.
- R9: AUTO REFRESH and LOAD MODE are legal only when every bank is idle. Otherwise they raise `illegal`. Neither command changes any bank state.
- R10: PRECHARGE with `pre_all` high makes every bank idle, whatever `bank_addr` is.
- R11: An illegal command pulses `illegal` for one cycle and leaves the addressed bank's state unaltered.
- R12: A command acts only on the bank selected by `bank_addr`. Other banks keep their state, apart from their own burst counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | log2(NUM_BANKS) | Bank the command addresses |
| pre_all | input | 1 | With PRECHARGE, selects all banks |
| burst_code | input | BL_W | Burst length as a power of two: 2^code beats |
| cmd_out | output | 4 | Decoded command of the last sampled edge |
| bank_state | output | 2*NUM_BANKS | Two-bit state per bank |
| illegal | output | 1 | One-cycle pulse for a command its state forbids |

## Verification
Every output is due at the same rising edge that samples the command. `cmd_out`, `illegal` and the addressed bank's state field can therefore be read one cycle after the inputs are applied. The bench drives the pins on the falling edge and reads results on the next falling edge, which is half a period after the edge that registers them. Burst completion is counted in edges from the edge that registered the READ or WRITE. For a burst of L beats, the bench checks that the bank still reads as bursting after L-1 further edges and as open after the L-th, so an off-by-one in the counter is caught either way.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_PRE     = 4'd3,
        CMD_REF     = 4'd4,
        CMD_LMR     = 4'd5,
        CMD_RD      = 4'd6,
        CMD_WR      = 4'd7,
        CMD_BST     = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        BS_IDLE   = 2'd0,
        BS_OPEN   = 2'd1,
        BS_READ   = 2'd2,
        BS_WRITE  = 2'd3
    } bank_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic cmd_e decode_pins(pins_t p);
        if (p.cs_n) return CMD_INHIBIT;
        case ({p.ras_n, p.cas_n, p.we_n})
            3'b011:  return CMD_ACT;
            3'b010:  return CMD_PRE;
            3'b001:  return CMD_REF;
            3'b000:  return CMD_LMR;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b110:  return CMD_BST;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic logic in_burst(bank_st_e s);
        return (s == BS_READ) || (s == BS_WRITE);
    endfunction

    function automatic logic is_legal(cmd_e c, bank_st_e s, logic all_idle);
        case (c)
            CMD_INHIBIT, CMD_NOP, CMD_PRE: return 1'b1;
            CMD_ACT:                       return s == BS_IDLE;
            CMD_REF, CMD_LMR:              return all_idle;
            CMD_RD, CMD_WR:                return s != BS_IDLE;
            CMD_BST:                       return in_burst(s);
            default:                       return 1'b0;
        endcase
    endfunction

    function automatic logic moves_bank(cmd_e c);
        return (c == CMD_ACT) || (c == CMD_PRE) || (c == CMD_RD) ||
               (c == CMD_WR) || (c == CMD_BST);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    pins_t pins;

    assign pins = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};
    assign cmd  = decode_pins(pins);
endmodule

// File: rtl/sdram_cmd_check.sv
module sdram_cmd_check
    import sdram_trk_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  cmd_e                     cmd,
    input  logic [BANK_W-1:0]        bank_sel,
    input  logic [2*NUM_BANKS-1:0]   states,
    output logic                     legal,
    output logic                     all_idle
);
    logic [NUM_BANKS-1:0] idle_vec;
    bank_st_e             sel_st;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_idle
        assign idle_vec[b] = (states[2*b +: 2] == BS_IDLE);
    end

    assign all_idle = &idle_vec;
    assign sel_st   = bank_st_e'(states[2*bank_sel +: 2]);
    assign legal    = is_legal(cmd, sel_st, all_idle);
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  cmd_e             cmd,
    input  logic [CNT_W-1:0] beats_m1,
    output bank_st_e         state
);
    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (in_burst(st_q)) begin
            if (cnt_q == '0) st_d = BS_OPEN;
            else             cnt_d = cnt_q - 1'b1;
        end
        if (hit) begin
            case (cmd)
                CMD_ACT: st_d = BS_OPEN;
                CMD_PRE: st_d = BS_IDLE;
                CMD_BST: st_d = BS_OPEN;
                CMD_RD: begin
                    st_d  = BS_READ;
                    cnt_d = beats_m1;
                end
                CMD_WR: begin
                    st_d  = BS_WRITE;
                    cnt_d = beats_m1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int BL_W      = 2,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BANK_W-1:0]      bank_addr,
    input  logic                   pre_all,
    input  logic [BL_W-1:0]        burst_code,
    output logic [3:0]             cmd_out,
    output logic [2*NUM_BANKS-1:0] bank_state,
    output logic                   illegal
);
    localparam int MAX_BEATS = 1 << ((1 << BL_W) - 1);
    localparam int CNT_W     = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

    cmd_e             cmd, cmd_q;
    logic             legal, all_idle, illegal_q;
    logic [CNT_W-1:0] beats_m1;
    bank_st_e         st [NUM_BANKS];

    assign beats_m1 = CNT_W'((32'd1 << burst_code) - 32'd1);

    sdram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_cmd_check #(.NUM_BANKS(NUM_BANKS)) u_check (
        .cmd      (cmd),
        .bank_sel (bank_addr),
        .states   (bank_state),
        .legal    (legal),
        .all_idle (all_idle)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic addr_hit, hit;
        assign addr_hit = (bank_addr == BANK_W'(b)) || ((cmd == CMD_PRE) && pre_all);
        assign hit      = legal && addr_hit && moves_bank(cmd);

        sdram_bank_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit),
            .cmd      (cmd),
            .beats_m1 (beats_m1),
            .state    (st[b])
        );

        assign bank_state[2*b +: 2] = st[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= CMD_INHIBIT;
            illegal_q <= 1'b0;
        end else begin
            cmd_q     <= cmd;
            illegal_q <= !legal;
        end
    end

    assign cmd_out = cmd_q;
    assign illegal = illegal_q;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         cs_n,
    input logic                         ras_n,
    input logic                         cas_n,
    input logic                         we_n,
    input logic [$clog2(NUM_BANKS)-1:0] bank_addr,
    input logic                         pre_all,
    input logic [3:0]                   cmd_out,
    input logic [2*NUM_BANKS-1:0]       bank_state,
    input logic                         illegal
);
    logic [$clog2(NUM_BANKS)-1:0] addr_q;
    logic [1:0]                   sel_now, sel_prev;

    always_ff @(posedge clk) addr_q <= bank_addr;

    assign sel_now  = bank_state[2*bank_addr +: 2];
    assign sel_prev = bank_state[2*addr_q +: 2];

    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_out == 4'd0) && !illegal); // R1

    AST_IDLE_COLUMN_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ras_n && !cas_n && sel_now == 2'd0) |=> illegal); // R4

    AST_OPEN_READ_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ras_n && !cas_n && we_n && sel_now == 2'd1)
        |=> (sel_prev == 2'd2) && !illegal); // R5

    AST_PRECHARGE_IDLES: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n && !pre_all)
        |=> (sel_prev == 2'd0) && !illegal); // R7

    AST_PREALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n && pre_all) |=> (bank_state == '0)); // R10

    AST_REFRESH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && !cas_n && bank_state != '0) |=> illegal); // R9

    AST_ACT_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && we_n && sel_now == 2'd1)
        |=> illegal && (sel_prev == 2'd1)); // R11
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
    localparam logic [3:0] P_INH = 4'b1010, P_NOP = 4'b0111, P_ACT = 4'b0011,
                           P_PRE = 4'b0010, P_REF = 4'b0001, P_LMR = 4'b0000,
                           P_RD  = 4'b0101, P_WR  = 4'b0100, P_BST = 4'b0110;

    logic       clk = 1'b0, rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] bank_addr = '0;
    logic       pre_all = 1'b0;
    logic [1:0] burst_code = 2'd3;
    logic [3:0] cmd_out;
    logic [7:0] bank_state;
    logic       illegal;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    sdram_cmd_tracker i_sdram_cmd_tracker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_addr(bank_addr), .pre_all(pre_all), .burst_code(burst_code),
        .cmd_out(cmd_out), .bank_state(bank_state), .illegal(illegal)
    );

    function automatic int st(int b);
        return int'(bank_state[2*b +: 2]);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] p, int bank, logic all = 1'b0);
        {cs_n, ras_n, cas_n, we_n} = p;
        bank_addr = 2'(bank);
        pre_all   = all;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        pre_all = 1'b0;
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) issue(P_NOP, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R3 reset cmd", int'(cmd_out), 0);
        chk("R3 reset illegal", int'(illegal), 0);
        chk("R3 reset states", int'(bank_state), 0);
        rst = 1'b0;
    endtask

    task automatic t_decode;
        issue(4'b1000, 0); chk("R1 inhibit code", int'(cmd_out), 0);
        chk("R1 inhibit legal", int'(illegal), 0);
        issue(P_NOP, 0); chk("R2 nop code", int'(cmd_out), 1);
        issue(P_ACT, 0); chk("R2 act code", int'(cmd_out), 2);
        chk("R4 act opens", st(0), 1); chk("R4 act legal", int'(illegal), 0);
        issue(P_PRE, 0); chk("R2 pre code", int'(cmd_out), 3); chk("R7 pre idles", st(0), 0);
        issue(P_PRE, 0); chk("R4 pre on idle legal", int'(illegal), 0);
        issue(P_REF, 0); chk("R2 ref code", int'(cmd_out), 4); chk("R9 ref legal idle", int'(illegal), 0);
        issue(P_LMR, 0); chk("R2 lmr code", int'(cmd_out), 5); chk("R9 lmr legal idle", int'(illegal), 0);
        issue(P_RD, 0);  chk("R2 rd code", int'(cmd_out), 6); chk("R4 rd idle illegal", int'(illegal), 1);
        chk("R11 rd idle keeps", st(0), 0);
        issue(P_WR, 0);  chk("R2 wr code", int'(cmd_out), 7); chk("R4 wr idle illegal", int'(illegal), 1);
        issue(P_BST, 0); chk("R2 bst code", int'(cmd_out), 8); chk("R4 bst idle illegal", int'(illegal), 1);
        nops(1); chk("R11 strobe one cycle", int'(illegal), 0);
    endtask

    task automatic t_row_active;
        burst_code = 2'd3;
        issue(P_ACT, 1); chk("R4 act bank1", st(1), 1);
        issue(P_ACT, 1); chk("R5 act open illegal", int'(illegal), 1); chk("R11 act keeps open", st(1), 1);
        issue(P_BST, 1); chk("R5 bst open illegal", int'(illegal), 1); chk("R11 bst keeps open", st(1), 1);
        issue(P_REF, 0); chk("R9 ref busy illegal", int'(illegal), 1);
        issue(P_LMR, 2); chk("R9 lmr busy illegal", int'(illegal), 1); chk("R9 lmr no change", st(1), 1);
        issue(4'b1101, 1); chk("R1 inhibit keeps", st(1), 1); chk("R1 inhibit quiet", int'(illegal), 0);
        issue(P_RD, 1); chk("R5 rd reading", st(1), 2); chk("R12 bank0 untouched", st(0), 0);
        issue(P_PRE, 1); chk("R7 pre truncates", st(1), 0); chk("R7 pre legal", int'(illegal), 0);
    endtask

    task automatic t_burst_len;
        burst_code = 2'd2;
        issue(P_ACT, 2);
        issue(P_RD, 2); chk("R5 rd bank2", st(2), 2);
        nops(3); chk("R8 4-beat still reading", st(2), 2);
        nops(1); chk("R8 4-beat done", st(2), 1);
        burst_code = 2'd0;
        issue(P_WR, 2); chk("R5 wr writing", st(2), 3);
        nops(1); chk("R8 1-beat done", st(2), 1);
        burst_code = 2'd1;
        issue(P_WR, 2); nops(1); chk("R8 2-beat mid", st(2), 3);
        nops(1); chk("R8 2-beat done", st(2), 1);
    endtask

    task automatic t_interrupt;
        burst_code = 2'd3;
        issue(P_RD, 2); nops(2);
        issue(P_WR, 2); chk("R6 wr in read", st(2), 3); chk("R6 wr legal", int'(illegal), 0);
        nops(7); chk("R6 restarted length", st(2), 3);
        nops(1); chk("R6 restart done", st(2), 1);
        issue(P_WR, 2); issue(P_RD, 2); chk("R6 rd in write", st(2), 2);
    endtask

    task automatic t_truncate;
        issue(P_BST, 2); chk("R7 bst to open", st(2), 1); chk("R7 bst legal", int'(illegal), 0);
        nops(2); chk("R7 stays open", st(2), 1);
        issue(P_WR, 2); issue(P_PRE, 2); chk("R7 pre in write", st(2), 0);
        nops(9); chk("R7 stays idle", st(2), 0);
    endtask

    task automatic t_preall;
        issue(P_ACT, 0); issue(P_ACT, 1); issue(P_ACT, 3);
        issue(P_RD, 3); chk("R12 bank3 reading", st(3), 2); chk("R12 bank0 open", st(0), 1);
        chk("R12 bank2 idle", st(2), 0);
        issue(P_PRE, 0, 1'b1); chk("R10 all idle", int'(bank_state), 0);
        issue(P_REF, 1); chk("R9 ref after preall", int'(illegal), 0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        t_reset();
        t_decode();
        t_row_active();
        t_burst_len();
        t_interrupt();
        t_truncate();
        t_preall();
        finish_run();
    end
endmodule